// File: doc/BRIEF.md
# Keyed-Access Watchdog Timer

This block is a watchdog for a system that must prove it is alive. A free-running up-counter advances once per slow reference tick. When it passes its all-ones value, the block raises a one-cycle reset request and reloads the counter from a software-set load value. Software sets a timeout of N ticks by writing 0 minus N into both the load register and the count register.

Software cannot start or stop the counter with a single stray write. The control register only acts on two consecutive writes of fixed key pairs. One pair turns the watchdog on and the other turns it off. Any other value, any key out of order, and any second word that is not the partner of the first are thrown away. Writes to the other registers may come between the two words of a pair without breaking it.

The bus side is a plain write strobe with a byte address and a combinational read data path. The tick input is a single-cycle strobe in the block's clock domain.

Top module: `keyed_watchdog`

## Requirements
- R1: After reset the watchdog is stopped (`running` low), the count and load registers read 0, and `rst_req` is low.
- R2: A write of 0xBBBB to the control register (byte offset 0x48), followed by a write of 0x4444 as the next control write, sets `running` high from the clock edge that takes the second write.
- R3: A write of 0xAAAA to the control register, followed by a write of 0x5555 as the next control write, clears `running` from the clock edge that takes the second write.
- R4: Some control writes leave `running` unchanged: a second word that is not the partner of the key before it, a second word with no first key before it, and any other value. Such a write also ends any pending sequence. Writes to other offsets between the two words do not end a pending sequence.
- R5: While running, each clock cycle with `tick_en` high adds one to the count. While stopped, the count holds its value.
- R6: A tick taken while the count is all ones sets `rst_req` high for exactly the next clock cycle. The count takes the load value at that same edge.
- R7: The load register (byte offset 0x2C) and the count register (byte offset 0x28) accept writes whether running or stopped. A count write in the same cycle as a tick wins over the tick, so the timeout restarts from the written value.
- R8: `rdata` shows the count at offset 0x28 and the load at offset 0x2C. At offset 0x48 it shows the running state in bit 0. All other offsets read 0.
- R9: With 0 minus N written to both load and count while running, the reset request follows the Nth tick after that and no earlier tick.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick_en | input | 1 | One-cycle strobe at the slow reference rate |
| wr_en | input | 1 | Register write strobe |
| addr | input | ADDR_W (8) | Byte address of the register access |
| wdata | input | DATA_W (32) | Write data |
| rdata | output | DATA_W (32) | Read data for `addr`, combinational |
| running | output | 1 | Watchdog is counting |
| rst_req | output | 1 | One-cycle reset request on overflow |

## Verification
A key-phase register that is stuck or left set wrongly shows up at `running`. The effect appears on the first control write that completes, or wrongly fails to complete, a pair, one edge after that write. A counter that increments wrongly or fails to reload shows up in the count readback one tick later. It also changes the exact tick that brings `rst_req`, so the bench counts ticks to the pulse and checks the cycle after it. Each key-pair check runs while the counter is idle, so a key decode fault cannot be hidden by a timer event.

// File: rtl/kwd_pkg.sv
`timescale 1ns/1ps
package kwd_pkg;

   // progress through a two-word key pair
   typedef enum logic [1:0] {
      PH_IDLE      = 2'd0,
      PH_HALT_HALF = 2'd1,
      PH_RUN_HALF  = 2'd2
   } key_phase_t;

endpackage

// File: rtl/kwd_key_gate.sv
`timescale 1ns/1ps
module kwd_key_gate #(
   parameter int                DATA_W     = 32,
   parameter logic [DATA_W-1:0] KEY_HALT_A = 'hAAAA,
   parameter logic [DATA_W-1:0] KEY_HALT_B = 'h5555,
   parameter logic [DATA_W-1:0] KEY_RUN_A  = 'hBBBB,
   parameter logic [DATA_W-1:0] KEY_RUN_B  = 'h4444
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ctrl_wr,
   input  logic [DATA_W-1:0] wdata,
   output logic              running
);
   import kwd_pkg::*;

   key_phase_t phase_q, phase_d;
   logic       run_q, run_d;

   if (KEY_HALT_A == KEY_RUN_A) begin : g_bad_keys
      $error("kwd_key_gate: first words of both key pairs must differ");
   end

   always_comb begin
      phase_d = phase_q;
      run_d   = run_q;
      if (ctrl_wr) begin
         phase_d = PH_IDLE;
         if (phase_q == PH_HALT_HALF && wdata == KEY_HALT_B) begin
            run_d = 1'b0;
         end else if (phase_q == PH_RUN_HALF && wdata == KEY_RUN_B) begin
            run_d = 1'b1;
         end else if (wdata == KEY_HALT_A) begin
            phase_d = PH_HALT_HALF;
         end else if (wdata == KEY_RUN_A) begin
            phase_d = PH_RUN_HALF;
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase_q <= PH_IDLE;
         run_q   <= 1'b0;
      end else begin
         phase_q <= phase_d;
         run_q   <= run_d;
      end
   end

   assign running = run_q;

   AST_RUN_PAIR: assert property (@(posedge clk) disable iff (!rst_n)
      (ctrl_wr && phase_q == PH_RUN_HALF && wdata == KEY_RUN_B) |=> running); // R2
   AST_HALT_PAIR: assert property (@(posedge clk) disable iff (!rst_n)
      (ctrl_wr && phase_q == PH_HALT_HALF && wdata == KEY_HALT_B) |=> !running); // R3
   AST_NO_STRAY_CHANGE: assert property (@(posedge clk) disable iff (!rst_n)
      (!ctrl_wr || (wdata != KEY_HALT_B && wdata != KEY_RUN_B)) |=> $stable(running)); // R4
   AST_PHASE_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(phase_q)); // R4

endmodule

// File: rtl/kwd_count_core.sv
`timescale 1ns/1ps
module kwd_count_core #(
   parameter int CNT_W            = 32,
   parameter bit REGISTERED_PULSE = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             running,
   input  logic             tick,
   input  logic             cnt_wr,
   input  logic             load_wr,
   input  logic [CNT_W-1:0] wdata,
   output logic [CNT_W-1:0] cnt,
   output logic [CNT_W-1:0] load,
   output logic             rst_req
);
   localparam logic [CNT_W-1:0] ALL_ONES = {CNT_W{1'b1}};
   localparam logic [CNT_W-1:0] ONE      = CNT_W'(1);

   logic [CNT_W-1:0] cnt_q, load_q;
   logic             step, wrap;

   if (CNT_W < 8) begin : g_bad_width
      $error("kwd_count_core: CNT_W must be at least 8");
   end

   assign step = running && tick && !cnt_wr;
   assign wrap = step && (cnt_q == ALL_ONES);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q  <= '0;
         load_q <= '0;
      end else begin
         if (load_wr) begin
            load_q <= wdata;
         end
         if (cnt_wr) begin
            cnt_q <= wdata;
         end else if (wrap) begin
            cnt_q <= load_q;
         end else if (step) begin
            cnt_q <= cnt_q + ONE;
         end
      end
   end

   if (REGISTERED_PULSE) begin : g_reg_pulse
      logic req_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) req_q <= 1'b0;
         else        req_q <= wrap;
      end
      assign rst_req = req_q;

      AST_RELOAD_ON_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
         rst_req |-> (cnt == $past(load))); // R6
      AST_PULSE_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
         rst_req |-> $past(running && tick && !cnt_wr)); // R6
   end else begin : g_comb_pulse
      assign rst_req = wrap;
   end

   assign cnt  = cnt_q;
   assign load = load_q;

   AST_STEP_ONE: assert property (@(posedge clk) disable iff (!rst_n)
      (running && tick && !cnt_wr && cnt != ALL_ONES) |=> (cnt == $past(cnt) + ONE)); // R5
   AST_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
      (!running && !cnt_wr) |=> $stable(cnt)); // R5
   AST_WRITE_WINS: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_wr |=> (cnt == $past(wdata))); // R7

endmodule

// File: rtl/kwd_read_mux.sv
`timescale 1ns/1ps
module kwd_read_mux #(
   parameter int               ADDR_W   = 8,
   parameter int               DATA_W   = 32,
   parameter int               CNT_W    = 32,
   parameter logic [ADDR_W-1:0] OFF_CNT  = 'h28,
   parameter logic [ADDR_W-1:0] OFF_LOAD = 'h2C,
   parameter logic [ADDR_W-1:0] OFF_CTRL = 'h48
) (
   input  logic [ADDR_W-1:0] addr,
   input  logic [CNT_W-1:0]  cnt,
   input  logic [CNT_W-1:0]  load,
   input  logic              running,
   output logic [DATA_W-1:0] rdata
);
   logic [DATA_W-1:0] cnt_x, load_x;

   if (CNT_W == DATA_W) begin : g_same
      assign cnt_x  = cnt;
      assign load_x = load;
   end else begin : g_pad
      assign cnt_x  = {{(DATA_W-CNT_W){1'b0}}, cnt};
      assign load_x = {{(DATA_W-CNT_W){1'b0}}, load};
   end

   always_comb begin
      rdata = '0;
      if (addr == OFF_CNT)       rdata = cnt_x;
      else if (addr == OFF_LOAD) rdata = load_x;
      else if (addr == OFF_CTRL) rdata = {{(DATA_W-1){1'b0}}, running};
   end

endmodule

// File: rtl/keyed_watchdog.sv
`timescale 1ns/1ps
module keyed_watchdog #(
   parameter int                DATA_W           = 32,
   parameter int                CNT_W            = 32,
   parameter int                ADDR_W           = 8,
   parameter logic [ADDR_W-1:0] OFF_CNT          = 'h28,
   parameter logic [ADDR_W-1:0] OFF_LOAD         = 'h2C,
   parameter logic [ADDR_W-1:0] OFF_CTRL         = 'h48,
   parameter logic [DATA_W-1:0] KEY_HALT_A       = 'hAAAA,
   parameter logic [DATA_W-1:0] KEY_HALT_B       = 'h5555,
   parameter logic [DATA_W-1:0] KEY_RUN_A        = 'hBBBB,
   parameter logic [DATA_W-1:0] KEY_RUN_B        = 'h4444,
   parameter bit                REGISTERED_PULSE = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tick_en,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] addr,
   input  logic [DATA_W-1:0] wdata,
   output logic [DATA_W-1:0] rdata,
   output logic              running,
   output logic              rst_req
);
   logic             ctrl_wr, cnt_wr, load_wr;
   logic [CNT_W-1:0] cnt, load;

   if (CNT_W > DATA_W) begin : g_bad_cnt
      $error("keyed_watchdog: CNT_W must not exceed DATA_W");
   end
   if (OFF_CNT == OFF_LOAD || OFF_CNT == OFF_CTRL || OFF_LOAD == OFF_CTRL) begin : g_bad_map
      $error("keyed_watchdog: register offsets must be distinct");
   end

   assign ctrl_wr = wr_en && (addr == OFF_CTRL);
   assign cnt_wr  = wr_en && (addr == OFF_CNT);
   assign load_wr = wr_en && (addr == OFF_LOAD);

   kwd_key_gate #(
      .DATA_W(DATA_W), .KEY_HALT_A(KEY_HALT_A), .KEY_HALT_B(KEY_HALT_B),
      .KEY_RUN_A(KEY_RUN_A), .KEY_RUN_B(KEY_RUN_B)
   ) u_keys (
      .clk(clk), .rst_n(rst_n), .ctrl_wr(ctrl_wr), .wdata(wdata), .running(running)
   );

   kwd_count_core #(.CNT_W(CNT_W), .REGISTERED_PULSE(REGISTERED_PULSE)) u_core (
      .clk(clk), .rst_n(rst_n), .running(running), .tick(tick_en),
      .cnt_wr(cnt_wr), .load_wr(load_wr), .wdata(wdata[CNT_W-1:0]),
      .cnt(cnt), .load(load), .rst_req(rst_req)
   );

   kwd_read_mux #(
      .ADDR_W(ADDR_W), .DATA_W(DATA_W), .CNT_W(CNT_W),
      .OFF_CNT(OFF_CNT), .OFF_LOAD(OFF_LOAD), .OFF_CTRL(OFF_CTRL)
   ) u_rd (
      .addr(addr), .cnt(cnt), .load(load), .running(running), .rdata(rdata)
   );

   AST_LOAD_TAKEN: assert property (@(posedge clk) disable iff (!rst_n)
      load_wr |=> (load == $past(wdata[CNT_W-1:0]))); // R7
   AST_REQ_NEEDS_RUN: assert property (@(posedge clk) disable iff (!rst_n)
      rst_req |-> $past(running)); // R6

endmodule

// File: tb/keyed_watchdog_test.sv
`timescale 1ns/1ps
module keyed_watchdog_test;
   localparam logic [7:0] A_CNT = 8'h28, A_LOAD = 8'h2C, A_CTRL = 8'h48;

   logic        clk = 1'b0, rst_n = 1'b0, tick_en = 1'b0, wr_en = 1'b0;
   logic [7:0]  addr = 8'h00;
   logic [31:0] wdata = 32'h0, rdata;
   logic        running, rst_req;
   int errors = 0, checks = 0, pulses = 0;
   bit done = 1'b0;

   keyed_watchdog uut (.clk(clk), .rst_n(rst_n), .tick_en(tick_en), .wr_en(wr_en),
      .addr(addr), .wdata(wdata), .rdata(rdata), .running(running), .rst_req(rst_req));

   always #2.5 clk = ~clk;

   always @(posedge clk) if (rst_n && rst_req) pulses++;

   // control-write vectors: {key word, expected running after it}
   localparam int NV = 18;
   localparam logic [16:0] VEC [NV] = '{
      {16'hBBBB,1'b0}, {16'h4444,1'b1}, {16'hAAAA,1'b1}, {16'h1234,1'b1},
      {16'h5555,1'b1}, {16'hAAAA,1'b1}, {16'h5555,1'b0}, {16'h4444,1'b0},
      {16'hBBBB,1'b0}, {16'h5555,1'b0}, {16'h4444,1'b0}, {16'hBBBB,1'b0},
      {16'h4444,1'b1}, {16'hAAAA,1'b1}, {16'hBBBB,1'b1}, {16'h5555,1'b1},
      {16'hAAAA,1'b1}, {16'h5555,1'b0}};

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [7:0] a, input logic [31:0] d);
      @(negedge clk);
      wr_en = 1'b1; addr = a; wdata = d;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic rd(input logic [7:0] a, output logic [31:0] d);
      @(negedge clk);
      addr = a;
      #1 d = rdata;
   endtask

   task automatic ticks(input int n);
      for (int i = 0; i < n; i++) begin
         @(negedge clk); tick_en = 1'b1;
         @(negedge clk); tick_en = 1'b0;
      end
   endtask

   initial begin
      logic [31:0] v;
      int p0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      // R1 reset state
      chk("R1 running", {31'b0, running}, 32'h0);
      chk("R1 rst_req", {31'b0, rst_req}, 32'h0);
      rd(A_CNT, v);  chk("R1 count", v, 32'h0);
      rd(A_LOAD, v); chk("R1 load", v, 32'h0);

      // R2 R3 R4 key-pair table
      for (int k = 0; k < NV; k++) begin
         wr(A_CTRL, {16'h0, VEC[k][16:1]});
         chk($sformatf("R2/R3/R4 vector %0d", k), {31'b0, running}, {31'b0, VEC[k][0]});
      end

      // R4: write to another offset between the two words keeps the pair
      wr(A_CTRL, 32'hBBBB);
      wr(A_LOAD, 32'h0);
      wr(A_CTRL, 32'h4444);
      chk("R4 interleaved pair", {31'b0, running}, 32'h1);
      // R4: full-width mismatch in upper bits is not a key
      wr(A_CTRL, 32'h0001AAAA);
      wr(A_CTRL, 32'h5555);
      chk("R4 upper bits", {31'b0, running}, 32'h1);

      // R8 readback of control and unmapped
      rd(A_CTRL, v); chk("R8 ctrl bit0", v, 32'h1);
      rd(8'h30, v);  chk("R8 unmapped", v, 32'h0);

      // R5 counting while running, hold while stopped
      wr(A_CNT, 32'd100);
      ticks(5);
      rd(A_CNT, v); chk("R5 count up", v, 32'd105);
      wr(A_CTRL, 32'hAAAA); wr(A_CTRL, 32'h5555);
      ticks(3);
      rd(A_CNT, v); chk("R5 hold stopped", v, 32'd105);
      // R7 writes accepted while stopped
      wr(A_LOAD, 32'hFFFF_FFF6);
      wr(A_CNT, 32'hFFFF_FFF6);
      rd(A_LOAD, v); chk("R7 load while stopped", v, 32'hFFFF_FFF6);
      rd(A_CNT, v);  chk("R7 count while stopped", v, 32'hFFFF_FFF6);

      // R9 / R6 timeout of 10 ticks
      wr(A_CTRL, 32'hBBBB); wr(A_CTRL, 32'h4444);
      p0 = pulses;
      ticks(9);
      chk("R9 no early request", pulses - p0, 0);
      rd(A_CNT, v); chk("R9 at all ones", v, 32'hFFFF_FFFF);
      ticks(1);
      chk("R6 request raised", {31'b0, rst_req}, 32'h1);
      rd(A_CNT, v); chk("R6 reload", v, 32'hFFFF_FFF6);
      chk("R6 one cycle", {31'b0, rst_req}, 32'h0);
      chk("R6 single pulse", pulses - p0, 1);

      // R7 count write wins over a simultaneous tick, restarts timeout
      ticks(5);
      @(negedge clk);
      wr_en = 1'b1; addr = A_CNT; wdata = 32'hFFFF_FFF6; tick_en = 1'b1;
      @(negedge clk);
      wr_en = 1'b0; tick_en = 1'b0;
      rd(A_CNT, v); chk("R7 write beats tick", v, 32'hFFFF_FFF6);
      p0 = pulses;
      ticks(9);
      chk("R7 restart no early request", pulses - p0, 0);
      ticks(1);
      chk("R7 restart request", {31'b0, rst_req}, 32'h1);

      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      #200000;
      if (!done) begin
         errors++; checks++;
         $display("FAIL watchdog: actual=hung expected=finished");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end
endmodule